// File: doc/BRIEF.md
# Divide-by-Four Sync Clock Generator with One-Cycle Phase Advance

This block derives a slow synchronization clock from a fast reference clock. A small phase counter, two bits wide by default, wraps once every four reference cycles. The block drives the divided clock onto an output pin and produces a one-cycle enable strobe for internal logic at every rising edge of that clock. When several devices must share the same sync-clock phase, their phases are lined up by slipping each divider forward one reference cycle at a time.

A slip is requested in one of two ways. The first is a rising edge on an external sync input while the hardware manual-sync enable is held at 1. The sync input is synchronized into the reference domain before its edge is detected. The second is a software request bit. It stays set until its single slip has been applied and then clears itself. A slip is made by stepping the counter by two instead of one, so the divided period that contains it is three reference cycles long.

A pin-disable bit can hold the output pin at a static 0. The counter and the enable strobe keep running while the pin is held low, so internal timing is not disturbed.

Top module: `sdiv_sync_clock`

## Requirements
- R1: With no slip requests, the phase counter advances by one each reference cycle. The pin is high while the new count is 0 or 1 and low while it is 2 or 3, so pin and strobe repeat every 4 cycles.
- R2: While `hw_sync_en` is 1, a rising edge on `sync_in` adds one extra count. The edge is sampled by a two-flop synchronizer, and the extra count is applied on the third rising clock edge after the edge on `sync_in`. As a result, the next rising edge of the sync clock arrives one reference cycle early.
- R3: While `hw_sync_en` is 0, activity on `sync_in` does not change the pin or the strobe sequence.
- R4: `hw_sync_en` is a level that the block never clears. Every edge detected while it is 1 produces its own slip.
- R5: A pulse on `sw_sync_set` produces exactly one slip. That slip is applied on the clock edge after the one that registered the pulse.
- R6: `sw_sync_pending` reads 1 from the edge that registers a pulse on `sw_sync_set` until the slip has been applied, and 0 after that. For a single pulse it is high for exactly one cycle.
- R7: While `pin_disable` is 1 (registered on a clock edge), `sync_clk_pin` is 0.
- R8: The counter and `sync_clk_en` keep their normal sequence, including slips, while `pin_disable` is 1.
- R9: `sync_clk_en` is high for one cycle whenever the counter wraps, including a wrap caused by a slip (3→1 or 2→0).
- R10: A `sync_in` level held high produces only one slip.
- R11: A synchronous reset clears the counter, the synchronizer, the edge detector, the software request and the strobe, and drives the pin to 0.
- R12: A hardware edge and a pending software request in the same cycle are merged into a single slip, and the software request still clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Asynchronous external sync input |
| hw_sync_en | input | 1 | Level enable for hardware-triggered slips |
| sw_sync_set | input | 1 | One-cycle pulse that sets the software slip request |
| pin_disable | input | 1 | Holds the sync clock pin at 0 |
| sync_clk_pin | output | 1 | Divided sync clock pin |
| sync_clk_en | output | 1 | One-cycle strobe at each sync clock rising edge |
| sw_sync_pending | output | 1 | Read-back of the software slip request |

## Verification
The bench builds the block with its default parameters: a 2-bit phase counter (divide by four) and a two-stage synchronizer. With these values every counter phase is reached within a few cycles. This makes both wrap paths of a slip (2→0 and 3→1), slips during the short high and low phases, and hardware/software coincidences easy to hit with both directed and random stimulus. A cycle-level model in the bench computes the expected pin, strobe and pending bit, and these are compared every cycle.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    localparam int unsigned SDIV_CNT_W_DFLT   = 2;
    localparam int unsigned SDIV_STAGES_DFLT  = 2;

    typedef struct packed {
        logic hw;
        logic sw;
    } slip_req_t;

    function automatic logic slip_any(input slip_req_t r);
        return r.hw | r.sw;
    endfunction

endpackage

// File: rtl/sdiv_edge_sync.sv
module sdiv_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES-1:0] shf_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shf_q  <= '0;
            last_q <= 1'b0;
        end else begin
            shf_q  <= {shf_q[STAGES-2:0], async_in};
            last_q <= shf_q[STAGES-1];
        end
    end

    assign rise_o = shf_q[STAGES-1] & ~last_q;

    // R10: a detected edge never lasts two cycles
    p_edge_single_r10: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/sdiv_phase_counter.sv
module sdiv_phase_counter #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slip,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o,
    output logic             high_nxt_o
);
    localparam int unsigned HALF = 2 ** (CNT_W - 1);

    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap_q;

    assign sum        = {1'b0, cnt_q} + (slip ? (CNT_W+1)'(2) : (CNT_W+1)'(1));
    assign high_nxt_o = (sum[CNT_W-1:0] < CNT_W'(HALF));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            cnt_q  <= sum[CNT_W-1:0];
            wrap_q <= sum[CNT_W];
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = wrap_q;

    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        !slip |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    p_slip_r2: assert property (@(posedge clk) disable iff (rst)
        slip |=> cnt_q == $past(cnt_q) + CNT_W'(2));
    p_strobe_low_count_r9: assert property (@(posedge clk) disable iff (rst)
        wrap_q |-> cnt_q < CNT_W'(2));

endmodule

// File: rtl/sdiv_pin_gate.sv
module sdiv_pin_gate (
    input  logic clk,
    input  logic rst,
    input  logic high_nxt,
    input  logic disable_in,
    output logic pin_o
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= high_nxt & ~disable_in;
    end

    assign pin_o = pin_q;

    p_pin_low_r7: assert property (@(posedge clk) disable iff (rst)
        disable_in |=> !pin_o);

endmodule

// File: rtl/sdiv_sync_clock.sv
module sdiv_sync_clock
    import sdiv_pkg::*;
#(
    parameter int unsigned CNT_W  = SDIV_CNT_W_DFLT,
    parameter int unsigned STAGES = SDIV_STAGES_DFLT
) (
    input  logic clk_ref,
    input  logic rst,
    input  logic sync_in,
    input  logic hw_sync_en,
    input  logic sw_sync_set,
    input  logic pin_disable,
    output logic sync_clk_pin,
    output logic sync_clk_en,
    output logic sw_sync_pending
);
    logic             hw_rise;
    logic             pend_q;
    slip_req_t        req;
    logic             slip;
    logic [CNT_W-1:0] cnt;
    logic             high_nxt;

    sdiv_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk      (clk_ref),
        .rst      (rst),
        .async_in (sync_in),
        .rise_o   (hw_rise)
    );

    assign req.hw = hw_rise & hw_sync_en;
    assign req.sw = pend_q;
    assign slip   = slip_any(req);

    // R12: coincident sources merge; the software request clears once applied
    always_ff @(posedge clk_ref) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= sw_sync_set | (pend_q & ~slip);
    end

    sdiv_phase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk_ref),
        .rst        (rst),
        .slip       (slip),
        .cnt_o      (cnt),
        .wrap_o     (sync_clk_en),
        .high_nxt_o (high_nxt)
    );

    sdiv_pin_gate u_pin (
        .clk        (clk_ref),
        .rst        (rst),
        .high_nxt   (high_nxt),
        .disable_in (pin_disable),
        .pin_o      (sync_clk_pin)
    );

    p_pend_clear_r6: assert property (@(posedge clk_ref) disable iff (rst)
        pend_q && !sw_sync_set |=> !sw_sync_pending);
    p_pend_set_r5: assert property (@(posedge clk_ref) disable iff (rst)
        sw_sync_set |=> sw_sync_pending);
    p_hw_ignored_r3: assert property (@(posedge clk_ref) disable iff (rst)
        !hw_sync_en && !pend_q |=> cnt == $past(cnt) + CNT_W'(1));

    assign sw_sync_pending = pend_q;

endmodule

// File: tb/sdiv_sync_clock_bench.sv
module sdiv_sync_clock_bench;
    localparam int PERIOD = 10;

    logic clk_ref = 1'b0;
    logic rst = 1'b1;
    logic sync_in = 1'b0, hw_sync_en = 1'b0, sw_sync_set = 1'b0, pin_disable = 1'b0;
    logic sync_clk_pin, sync_clk_en, sw_sync_pending;

    int n_chk = 0, n_fail = 0;
    string tag = "R11";
    bit cmp_on = 1'b0;

    always #(PERIOD/2) clk_ref = ~clk_ref;

    sdiv_sync_clock u_sdiv_sync_clock (
        .clk_ref(clk_ref), .rst(rst), .sync_in(sync_in), .hw_sync_en(hw_sync_en),
        .sw_sync_set(sw_sync_set), .pin_disable(pin_disable),
        .sync_clk_pin(sync_clk_pin), .sync_clk_en(sync_clk_en),
        .sw_sync_pending(sw_sync_pending)
    );

    // Reference model
    int  m_cnt = 0;
    bit  m_s1 = 0, m_s2 = 0, m_prev = 0, m_pend = 0, m_wrap = 0, m_pin = 0;

    function automatic int next_sum(int c, bit slip);
        return c + 1 + (slip ? 1 : 0);
    endfunction

    always @(posedge clk_ref) begin
        if (rst) begin
            m_cnt <= 0; m_s1 <= 0; m_s2 <= 0; m_prev <= 0;
            m_pend <= 0; m_wrap <= 0; m_pin <= 0;
        end else begin
            bit slip;
            int s;
            slip = (hw_sync_en & m_s2 & ~m_prev) | m_pend;
            s = next_sum(m_cnt, slip);
            m_cnt  <= s % 4;
            m_wrap <= (s >= 4);
            m_pin  <= ((s % 4) < 2) & ~pin_disable;
            m_pend <= sw_sync_set | (m_pend & ~slip);
            m_s1 <= sync_in; m_s2 <= m_s1; m_prev <= m_s2;
        end
    end

    task automatic check(string t, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", t, what, act, exp, $time);
        end
    endtask

    always @(negedge clk_ref) begin
        if (cmp_on) begin
            check(pin_disable ? "R7" : tag, "pin", sync_clk_pin, m_pin);
            check(pin_disable ? "R8" : tag, "strobe R9", sync_clk_en, m_wrap);
            check(tag, "pending R6", sw_sync_pending, m_pend);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk_ref);
    endtask

    task automatic pulse_sync(int hi, int lo);
        sync_in = 1'b1; cyc(hi); sync_in = 1'b0; cyc(lo);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        cyc(3);
        // R11: reset state
        check("R11", "pin", sync_clk_pin, 1'b0);
        check("R11", "strobe", sync_clk_en, 1'b0);
        check("R11", "pending", sw_sync_pending, 1'b0);
        rst = 1'b0;
        cmp_on = 1'b1;

        tag = "R1";  cyc(20);
        tag = "R2";  hw_sync_en = 1'b1;
        for (int i = 0; i < 8; i++) pulse_sync(1, 3 + i);
        tag = "R10"; pulse_sync(25, 6);
        tag = "R4";  for (int i = 0; i < 10; i++) pulse_sync(2, 2);
        tag = "R3";  hw_sync_en = 1'b0;
        for (int i = 0; i < 10; i++) pulse_sync(1 + i % 3, 2);
        tag = "R5";
        for (int i = 0; i < 6; i++) begin
            sw_sync_set = 1'b1; cyc(1); sw_sync_set = 1'b0; cyc(3 + i);
        end
        tag = "R12"; hw_sync_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            sync_in = 1'b1; cyc(1 + i % 2); sw_sync_set = 1'b1; cyc(1);
            sw_sync_set = 1'b0; sync_in = 1'b0; cyc(4);
        end
        tag = "R8";  pin_disable = 1'b1;
        for (int i = 0; i < 5; i++) pulse_sync(1, 4);
        sw_sync_set = 1'b1; cyc(1); sw_sync_set = 1'b0; cyc(8);
        pin_disable = 1'b0; cyc(4);

        tag = "R11"; rst = 1'b1; cyc(2);
        check("R11", "pin after reset", sync_clk_pin, 1'b0);
        check("R11", "pending after reset", sw_sync_pending, 1'b0);
        rst = 1'b0; cyc(4);

        tag = "R9";
        for (int i = 0; i < 3000; i++) begin
            sync_in     = ($urandom % 4) == 0;
            hw_sync_en  = ($urandom % 3) != 0;
            sw_sync_set = ($urandom % 9) == 0;
            pin_disable = ($urandom % 7) == 0;
            cyc(1);
        end
        sync_in = 1'b0; sw_sync_set = 1'b0; pin_disable = 1'b0; cyc(6);
        cmp_on = 1'b0;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule